// File: doc/BRIEF.md
# I2C address alias remapper

This block sits behind the bit-level engine of a local I2C target port. When the first address of a transaction has been shifted in, it classifies the 7-bit address into one of four classes. The address may belong to this device itself. It may hit one entry of an alias table that stands for a device on the far side of a control link. It may hit the alias of the remote link partner, or, in pass-all mode, simply not be local. Otherwise it belongs to nobody. For the two forwarding classes it supplies the physical address that replaces the alias before the transaction is sent over the link, and it raises a forward flag for the transport.

Configuration is held in a small write-only register file inside the block. The file holds a control byte, the local address, the remote-partner alias, the remote-partner ID with its freeze bit, and per-entry aliases and physical targets. While the link reports lock and the freeze bit is clear, the remote-partner ID follows the value learned from the link. The decode result is registered one cycle after the address strobe and held until the next start condition.

Top module: `i2c_alias_remap`

## Requirements
- R1: After reset the outputs read class NONE (0), remap 0, index 0 and forward 0. The register-held local address is 0x60 and pass-through is enabled. All aliases, all targets, the remote alias and the remote ID are 0, and all other control bits are 0.
- R2: The local address is `strap_addr_i` when control bit 2 (register offset 0) is 0, and the register at offset 1, bits 7:1, when that bit is 1. A decoded address equal to it gives class LOCAL (1) with forward 0 and remap 0.
- R3: Suppose pass-through is enabled (control bit 0) and the address equals a nonzero alias N (offset 16+N, bits 7:1). The class is then ALIAS (2), with index N, remap equal to target N (offset 24+N, bits 7:1) and forward 1. When several aliases match, the lowest N wins.
- R4: An alias entry holding 0 never matches, so address 0 does not hit cleared entries.
- R5: With pass-through enabled, and the address matching neither the local address nor any alias entry, an address equal to the remote alias gives class REMOTE (3). This requires the remote alias (offset 2, bits 7:1) and the remote ID (offset 3, bits 7:1) both to be nonzero. Remap is then the remote ID and forward is 1. A zero remote alias or a zero remote ID gives NONE.
- R6: With pass-all (control bit 1) and pass-through enabled and a nonzero remote ID, every address that is neither local nor an alias hit gives REMOTE with remap equal to the remote ID.
- R7: With pass-through disabled, no address is forwarded: alias, remote-alias and pass-all hits give NONE, while the local address still gives LOCAL.
- R8: An address that equals both the local address and an alias gives LOCAL.
- R9: While `link_lock_i` is 1 and the freeze bit (offset 3, bit 0) is 0, the remote ID is loaded from `link_id_i` every cycle. While the freeze bit is 1, the remote ID keeps the value written. A register write in the same cycle takes precedence over the link load.
- R10: Only the first `addr_vld_i` after a `start_i` is decoded, and its result appears on the outputs in the cycle after the strobe. Later strobes are ignored until the next start, as are strobes before any start. A start returns the outputs to NONE, remap 0, index 0 and forward 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 5 | Configuration register offset |
| cfg_wdata_i | input | 8 | Configuration write data (addresses in bits 7:1) |
| link_lock_i | input | 1 | Link reports lock |
| link_id_i | input | 7 | Remote-partner ID learned from the link |
| strap_addr_i | input | 7 | Local address from strap inputs |
| start_i | input | 1 | Start condition strobe |
| addr_vld_i | input | 1 | Address field complete strobe |
| addr_i | input | 7 | 7-bit address (bits 7:1 of the address byte) |
| hit_cls_o | output | 2 | Class: 0 NONE, 1 LOCAL, 2 ALIAS, 3 REMOTE |
| remap_o | output | 7 | Physical address to forward |
| alias_idx_o | output | 3 | Winning alias entry |
| fwd_o | output | 1 | Forward over the control link |

## Verification
Directed cases try duplicate aliases, to separate lowest-index priority from any match. They try an address that is both local and aliased, to show local precedence. They try address 0 against cleared entries, which distinguishes disabled from matching. A zero remote ID under pass-all and pass-through off check that forwarding is gated rather than merely remapped. A lock and freeze sequence with a changing link ID tells a frozen remote ID from a followed one. Extra address strobes without a start check the hold behaviour. Random phases draw addresses and register values from a small pool so that collisions between classes are frequent. Each result is compared with a bench model of the priority rules.

// File: rtl/i2c_remap_pkg.sv
package i2c_remap_pkg;
  typedef enum logic [1:0] {
    HIT_NONE   = 2'd0,
    HIT_LOCAL  = 2'd1,
    HIT_ALIAS  = 2'd2,
    HIT_REMOTE = 2'd3
  } hit_cls_e;

  // control byte bit positions
  localparam int CTRL_PASS_EN  = 0;
  localparam int CTRL_PASS_ALL = 1;
  localparam int CTRL_LOC_SEL  = 2;
endpackage

// File: rtl/remap_cfg_regs.sv
module remap_cfg_regs
  import i2c_remap_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int NUM_ALIAS  = 8,
  parameter int CFG_AW     = 5,
  parameter int OFF_CTRL   = 0,
  parameter int OFF_LOCAL  = 1,
  parameter int OFF_RALIAS = 2,
  parameter int OFF_RID    = 3,
  parameter int ALIAS_BASE = 16,
  parameter int TGT_BASE   = 24,
  parameter logic [ADDR_W-1:0] LOCAL_DEF = 7'h60
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               we,
  input  logic [CFG_AW-1:0]                  waddr,
  input  logic [ADDR_W:0]                    wdata,
  input  logic                               link_lock,
  input  logic [ADDR_W-1:0]                  link_id,
  output logic                               pass_en,
  output logic                               pass_all,
  output logic                               loc_sel,
  output logic [ADDR_W-1:0]                  local_reg,
  output logic [ADDR_W-1:0]                  ralias,
  output logic [ADDR_W-1:0]                  rid,
  output logic [NUM_ALIAS-1:0][ADDR_W-1:0]   alias_tbl,
  output logic [NUM_ALIAS-1:0][ADDR_W-1:0]   tgt_tbl
);
  logic freeze;
  logic wr_ctrl, wr_local, wr_ralias, wr_rid;

  assign wr_ctrl   = we && (waddr == CFG_AW'(OFF_CTRL));
  assign wr_local  = we && (waddr == CFG_AW'(OFF_LOCAL));
  assign wr_ralias = we && (waddr == CFG_AW'(OFF_RALIAS));
  assign wr_rid    = we && (waddr == CFG_AW'(OFF_RID));

  always_ff @(posedge clk) begin
    if (rst) begin
      pass_en  <= 1'b1;
      pass_all <= 1'b0;
      loc_sel  <= 1'b0;
    end else if (wr_ctrl) begin
      pass_en  <= wdata[CTRL_PASS_EN];
      pass_all <= wdata[CTRL_PASS_ALL];
      loc_sel  <= wdata[CTRL_LOC_SEL];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           local_reg <= LOCAL_DEF;
    else if (wr_local) local_reg <= wdata[ADDR_W:1];
  end

  always_ff @(posedge clk) begin
    if (rst)            ralias <= '0;
    else if (wr_ralias) ralias <= wdata[ADDR_W:1];
  end

  // remote ID: software write first, then link learning unless frozen
  always_ff @(posedge clk) begin
    if (rst) begin
      rid    <= '0;
      freeze <= 1'b0;
    end else if (wr_rid) begin
      rid    <= wdata[ADDR_W:1];
      freeze <= wdata[0];
    end else if (link_lock && !freeze) begin
      rid    <= link_id;
    end
  end

  generate
    for (genvar g = 0; g < NUM_ALIAS; g++) begin : g_entry
      always_ff @(posedge clk) begin
        if (rst)
          alias_tbl[g] <= '0;
        else if (we && (waddr == CFG_AW'(ALIAS_BASE + g)))
          alias_tbl[g] <= wdata[ADDR_W:1];
      end
      always_ff @(posedge clk) begin
        if (rst)
          tgt_tbl[g] <= '0;
        else if (we && (waddr == CFG_AW'(TGT_BASE + g)))
          tgt_tbl[g] <= wdata[ADDR_W:1];
      end
    end
  endgenerate

  // R9
  freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (freeze && !wr_rid) |=> $stable(rid));

  // R9
  link_load_chk: assert property (@(posedge clk) disable iff (rst)
    (link_lock && !freeze && !wr_rid) |=> (rid == $past(link_id)));
endmodule

// File: rtl/remap_alias_cam.sv
module remap_alias_cam #(
  parameter int ADDR_W    = 7,
  parameter int NUM_ALIAS = 8,
  parameter int IDX_W     = 3
) (
  input  logic [ADDR_W-1:0]                addr,
  input  logic [NUM_ALIAS-1:0][ADDR_W-1:0] alias_tbl,
  input  logic [NUM_ALIAS-1:0][ADDR_W-1:0] tgt_tbl,
  output logic                             hit,
  output logic [IDX_W-1:0]                 idx,
  output logic [ADDR_W-1:0]                tgt
);
  logic [NUM_ALIAS-1:0] match;

  generate
    for (genvar g = 0; g < NUM_ALIAS; g++) begin : g_cmp
      // a cleared entry is disabled
      assign match[g] = (alias_tbl[g] != '0) && (alias_tbl[g] == addr);
    end
  endgenerate

  // descending scan: the last assignment is the lowest matching entry
  always_comb begin
    idx = '0;
    for (int i = NUM_ALIAS - 1; i >= 0; i--) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end

  assign hit = |match;
  assign tgt = tgt_tbl[idx];
endmodule

// File: rtl/remap_decode.sv
module remap_decode
  import i2c_remap_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              addr_vld,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] strap_addr,
  input  logic              pass_en,
  input  logic              pass_all,
  input  logic              loc_sel,
  input  logic [ADDR_W-1:0] local_reg,
  input  logic [ADDR_W-1:0] ralias,
  input  logic [ADDR_W-1:0] rid,
  input  logic              cam_hit,
  input  logic [IDX_W-1:0]  cam_idx,
  input  logic [ADDR_W-1:0] cam_tgt,
  output logic [1:0]        cls_q,
  output logic [ADDR_W-1:0] remap_q,
  output logic [IDX_W-1:0]  idx_q,
  output logic              fwd_q
);
  hit_cls_e          cls_d;
  logic [ADDR_W-1:0] remap_d;
  logic [IDX_W-1:0]  idx_d;
  logic [ADDR_W-1:0] local_addr;
  logic              remote_ok, remote_hit, armed, take;

  assign local_addr = loc_sel ? local_reg : strap_addr;
  assign remote_ok  = pass_en && (rid != '0);
  assign remote_hit = remote_ok &&
                      (pass_all || ((ralias != '0) && (addr == ralias)));

  // priority: local, alias table, remote alias / pass-all
  always_comb begin
    cls_d   = HIT_NONE;
    remap_d = '0;
    idx_d   = '0;
    if (addr == local_addr) begin
      cls_d = HIT_LOCAL;
    end else if (pass_en && cam_hit) begin
      cls_d   = HIT_ALIAS;
      remap_d = cam_tgt;
      idx_d   = cam_idx;
    end else if (remote_hit) begin
      cls_d   = HIT_REMOTE;
      remap_d = rid;
    end
  end

  assign take = addr_vld && armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
    end else if (start) begin
      armed <= 1'b1;
    end else if (addr_vld) begin
      armed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cls_q   <= HIT_NONE;
      remap_q <= '0;
      idx_q   <= '0;
      fwd_q   <= 1'b0;
    end else if (take) begin
      cls_q   <= cls_d;
      remap_q <= remap_d;
      idx_q   <= idx_d;
      fwd_q   <= (cls_d == HIT_ALIAS) || (cls_d == HIT_REMOTE);
    end else if (start) begin
      cls_q   <= HIT_NONE;
      remap_q <= '0;
      idx_q   <= '0;
      fwd_q   <= 1'b0;
    end
  end

  // R10
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !take) |=> (cls_q == HIT_NONE && !fwd_q && remap_q == '0));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!start && !take) |=> ($stable(cls_q) && $stable(remap_q) && $stable(fwd_q)));

  // R8
  local_nofwd_chk: assert property (@(posedge clk) disable iff (rst)
    (cls_q == HIT_LOCAL) |-> (!fwd_q && remap_q == '0));

  // R5
  remote_nz_chk: assert property (@(posedge clk) disable iff (rst)
    (cls_q == HIT_REMOTE) |-> (fwd_q && remap_q != '0));

  // R7
  pass_off_chk: assert property (@(posedge clk) disable iff (rst)
    (take && !pass_en) |=> !fwd_q);
endmodule

// File: rtl/i2c_alias_remap.sv
module i2c_alias_remap
  import i2c_remap_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int NUM_ALIAS = 8,
  parameter int CFG_AW    = 5,
  parameter int IDX_W     = (NUM_ALIAS > 1) ? $clog2(NUM_ALIAS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [ADDR_W:0]   cfg_wdata_i,
  input  logic              link_lock_i,
  input  logic [ADDR_W-1:0] link_id_i,
  input  logic [ADDR_W-1:0] strap_addr_i,
  input  logic              start_i,
  input  logic              addr_vld_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [1:0]        hit_cls_o,
  output logic [ADDR_W-1:0] remap_o,
  output logic [IDX_W-1:0]  alias_idx_o,
  output logic              fwd_o
);
  localparam int ALIAS_BASE = 2 ** (CFG_AW - 1);
  localparam int TGT_BASE   = ALIAS_BASE + ALIAS_BASE / 2;

  logic                             pass_en, pass_all, loc_sel;
  logic [ADDR_W-1:0]                local_reg, ralias, rid;
  logic [NUM_ALIAS-1:0][ADDR_W-1:0] alias_tbl, tgt_tbl;
  logic                             cam_hit;
  logic [IDX_W-1:0]                 cam_idx;
  logic [ADDR_W-1:0]                cam_tgt;

  remap_cfg_regs #(
    .ADDR_W(ADDR_W), .NUM_ALIAS(NUM_ALIAS), .CFG_AW(CFG_AW),
    .ALIAS_BASE(ALIAS_BASE), .TGT_BASE(TGT_BASE)
  ) cfg_u (
    .clk(clk), .rst(rst), .we(cfg_we_i), .waddr(cfg_addr_i),
    .wdata(cfg_wdata_i), .link_lock(link_lock_i), .link_id(link_id_i),
    .pass_en(pass_en), .pass_all(pass_all), .loc_sel(loc_sel),
    .local_reg(local_reg), .ralias(ralias), .rid(rid),
    .alias_tbl(alias_tbl), .tgt_tbl(tgt_tbl)
  );

  remap_alias_cam #(
    .ADDR_W(ADDR_W), .NUM_ALIAS(NUM_ALIAS), .IDX_W(IDX_W)
  ) cam_u (
    .addr(addr_i), .alias_tbl(alias_tbl), .tgt_tbl(tgt_tbl),
    .hit(cam_hit), .idx(cam_idx), .tgt(cam_tgt)
  );

  remap_decode #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) dec_u (
    .clk(clk), .rst(rst), .start(start_i), .addr_vld(addr_vld_i),
    .addr(addr_i), .strap_addr(strap_addr_i), .pass_en(pass_en),
    .pass_all(pass_all), .loc_sel(loc_sel), .local_reg(local_reg),
    .ralias(ralias), .rid(rid), .cam_hit(cam_hit), .cam_idx(cam_idx),
    .cam_tgt(cam_tgt), .cls_q(hit_cls_o), .remap_q(remap_o),
    .idx_q(alias_idx_o), .fwd_q(fwd_o)
  );

  // R3
  alias_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_cls_o == HIT_ALIAS) |-> fwd_o);
endmodule

// File: tb/i2c_alias_remap_tb.sv
module i2c_alias_remap_tb_top;
  localparam logic [6:0] STRAP = 7'h11;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we_i = 1'b0;
  logic [4:0] cfg_addr_i = '0;
  logic [7:0] cfg_wdata_i = '0;
  logic       link_lock_i = 1'b0;
  logic [6:0] link_id_i = '0;
  logic [6:0] strap_addr_i = STRAP;
  logic       start_i = 1'b0;
  logic       addr_vld_i = 1'b0;
  logic [6:0] addr_i = '0;
  logic [1:0] hit_cls_o;
  logic [6:0] remap_o;
  logic [2:0] alias_idx_o;
  logic       fwd_o;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  i2c_alias_remap dut_i (
    .clk(clk), .rst(rst), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i), .link_lock_i(link_lock_i), .link_id_i(link_id_i),
    .strap_addr_i(strap_addr_i), .start_i(start_i), .addr_vld_i(addr_vld_i),
    .addr_i(addr_i), .hit_cls_o(hit_cls_o), .remap_o(remap_o),
    .alias_idx_o(alias_idx_o), .fwd_o(fwd_o)
  );

  typedef struct packed {
    logic [1:0] cls;
    logic       fwd;
    logic [6:0] remap;
    logic [2:0] idx;
  } res_t;

  // bench copy of configuration
  logic       m_pen = 1'b1, m_pall = 1'b0, m_sel = 1'b0;
  logic [6:0] m_local = 7'h60, m_ralias = '0, m_rid = '0;
  logic [6:0] m_alias [8];
  logic [6:0] m_tgt [8];

  function automatic res_t model(input logic [6:0] a);
    res_t r;
    logic [6:0] loc;
    logic found;
    r = '0;
    found = 1'b0;
    loc = m_sel ? m_local : STRAP;
    if (a == loc) begin
      r.cls = 2'd1;
    end else begin
      if (m_pen) begin
        for (int i = 0; i < 8; i++) begin
          if (!found && m_alias[i] != 0 && m_alias[i] == a) begin
            found = 1'b1;
            r.cls = 2'd2; r.fwd = 1'b1; r.remap = m_tgt[i]; r.idx = 3'(i);
          end
        end
      end
      if (!found && m_pen && m_rid != 0 &&
          (m_pall || (m_ralias != 0 && a == m_ralias))) begin
        r.cls = 2'd3; r.fwd = 1'b1; r.remap = m_rid;
      end
    end
    return r;
  endfunction

  task automatic check(input string tag, input res_t exp);
    res_t act;
    act = '{hit_cls_o, fwd_o, remap_o, alias_idx_o};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: cls=%0d fwd=%0d remap=%h idx=%0d expected cls=%0d fwd=%0d remap=%h idx=%0d",
               tag, act.cls, act.fwd, act.remap, act.idx,
               exp.cls, exp.fwd, exp.remap, exp.idx);
    end
  endtask

  task automatic wr(input logic [4:0] off, input logic [7:0] d);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_addr_i = off; cfg_wdata_i = d;
    @(negedge clk);
    cfg_we_i = 1'b0;
    case (off)
      5'd0: begin m_pen = d[0]; m_pall = d[1]; m_sel = d[2]; end
      5'd1: m_local = d[7:1];
      5'd2: m_ralias = d[7:1];
      5'd3: m_rid = d[7:1];
      default: begin
        if (off >= 5'd16 && off < 5'd24) m_alias[off - 5'd16] = d[7:1];
        else if (off >= 5'd24) m_tgt[off - 5'd24] = d[7:1];
      end
    endcase
  endtask

  // start, then address strobe; ends at the negedge after the capture edge
  task automatic decode(input logic [6:0] a);
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; addr_vld_i = 1'b1; addr_i = a;
    @(negedge clk);
    addr_vld_i = 1'b0;
  endtask

  task automatic dec_chk(input string tag, input logic [6:0] a);
    decode(a);
    check(tag, model(a));
  endtask

  function automatic logic [6:0] pick();
    case ($urandom % 9)
      0: return 7'h00;
      1: return STRAP;
      2: return 7'h20;
      3: return 7'h30;
      4: return 7'h44;
      5: return 7'h60;
      6: return 7'h5A;
      7: return 7'h22;
      default: return 7'($urandom);
    endcase
  endfunction

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 8; i++) begin m_alias[i] = '0; m_tgt[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset outputs", '0);

    // R10 strobe before any start is ignored
    @(negedge clk); addr_vld_i = 1'b1; addr_i = STRAP;
    @(negedge clk); addr_vld_i = 1'b0;
    check("R10 strobe without start", '0);

    // R1 pass-through enabled out of reset
    wr(5'd16, {7'h20, 1'b0});
    wr(5'd24, {7'h50, 1'b0});
    dec_chk("R1 pass enabled at reset", 7'h20);
    check("R3 alias 0 hit", '{2'd2, 1'b1, 7'h50, 3'd0});

    // R2 strap address, then register default 0x60
    dec_chk("R2 strap local", STRAP);
    dec_chk("R2 0x60 not local on strap", 7'h60);
    wr(5'd0, 8'h05);
    dec_chk("R1 register local default", 7'h60);
    check("R2 register local", '{2'd1, 1'b0, 7'h00, 3'd0});
    dec_chk("R2 strap not local on register", STRAP);

    // R3 duplicate aliases, lowest index wins; last entry
    wr(5'd19, {7'h30, 1'b0}); wr(5'd27, {7'h13, 1'b0});
    wr(5'd21, {7'h30, 1'b0}); wr(5'd29, {7'h15, 1'b0});
    dec_chk("R3 duplicate lowest wins", 7'h30);
    check("R3 duplicate idx3", '{2'd2, 1'b1, 7'h13, 3'd3});
    wr(5'd23, {7'h37, 1'b0}); wr(5'd31, {7'h77, 1'b0});
    dec_chk("R3 entry 7", 7'h37);

    // R4 zero address against cleared entries
    dec_chk("R4 zero never matches", 7'h00);
    check("R4 zero none", '0);

    // R5 remote alias
    wr(5'd2, {7'h44, 1'b0});
    dec_chk("R5 remote id zero disables", 7'h44);
    check("R5 zero id none", '0);
    wr(5'd3, {7'h22, 1'b0});
    dec_chk("R5 remote alias hit", 7'h44);
    check("R5 remap to id", '{2'd3, 1'b1, 7'h22, 3'd0});
    dec_chk("R5 non-alias none", 7'h45);

    // R6 pass-all
    wr(5'd0, 8'h07);
    dec_chk("R6 pass-all other", 7'h5A);
    check("R6 pass-all remap", '{2'd3, 1'b1, 7'h22, 3'd0});
    dec_chk("R6 pass-all local kept", 7'h60);
    dec_chk("R6 pass-all alias first", 7'h30);
    wr(5'd3, {7'h00, 1'b0});
    dec_chk("R6 pass-all zero id", 7'h5A);
    wr(5'd3, {7'h22, 1'b0});

    // R8 local beats alias
    wr(5'd17, {7'h60, 1'b0}); wr(5'd25, {7'h66, 1'b0});
    dec_chk("R8 local over alias", 7'h60);
    check("R8 local class", '{2'd1, 1'b0, 7'h00, 3'd0});

    // R7 pass-through off
    wr(5'd0, 8'h06);
    dec_chk("R7 alias blocked", 7'h30);
    dec_chk("R7 remote blocked", 7'h44);
    dec_chk("R7 pass-all blocked", 7'h5A);
    check("R7 none", '0);
    dec_chk("R7 local still", 7'h60);
    wr(5'd0, 8'h05);

    // R9 lock load, freeze, unfreeze
    @(negedge clk); link_lock_i = 1'b1; link_id_i = 7'h33;
    repeat (2) @(negedge clk);
    m_rid = 7'h33;
    dec_chk("R9 link load", 7'h44);
    check("R9 loaded 0x33", '{2'd3, 1'b1, 7'h33, 3'd0});
    wr(5'd3, {7'h22, 1'b1});
    link_id_i = 7'h55;
    repeat (3) @(negedge clk);
    dec_chk("R9 frozen keeps written", 7'h44);
    check("R9 frozen 0x22", '{2'd3, 1'b1, 7'h22, 3'd0});
    wr(5'd3, {7'h22, 1'b0});
    @(negedge clk);
    m_rid = 7'h55;
    dec_chk("R9 unfreeze follows link", 7'h44);
    @(negedge clk); link_lock_i = 1'b0;

    // R10 hold, ignore later strobes, clear on start
    decode(7'h30);
    check("R10 captured", model(7'h30));
    @(negedge clk); addr_vld_i = 1'b1; addr_i = 7'h60;
    @(negedge clk); addr_vld_i = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 held after extra strobe", model(7'h30));
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check("R10 start clears", '0);
    @(negedge clk); addr_vld_i = 1'b1; addr_i = 7'h30;
    check("R10 not before edge", '0);
    @(negedge clk); addr_vld_i = 1'b0;
    check("R10 one cycle latency", model(7'h30));

    // random mix of configuration writes and decodes
    for (int n = 0; n < 400; n++) begin
      if ($urandom % 3 == 0) begin
        int k;
        k = $urandom % 20;
        if (k < 2)       wr(5'd0, {5'd0, 1'($urandom), 1'($urandom), ($urandom % 4 != 0)});
        else if (k < 3)  wr(5'd1, {pick(), 1'b0});
        else if (k < 4)  wr(5'd2, {pick(), 1'b0});
        else if (k < 5)  wr(5'd3, {pick(), 1'($urandom)});
        else if (k < 12) wr(5'(16 + ($urandom % 8)), {pick(), 1'b0});
        else             wr(5'(24 + ($urandom % 8)), {7'($urandom), 1'b0});
      end
      dec_chk("R3 R5 R6 random decode", pick());
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule